// File: doc/BRIEF.md
# Microwire Command/Response Master

This block is the controlling end of a three-wire command/response serial link. For each frame it lowers an active-low select line and waits out a setup margin. It then shifts an 8-bit command word out of its data output, most significant bit first. One quiet bit period follows. The block then shifts in a reply of 4 to 16 bits from its data input, also most significant bit first. The serial clock comes from a programmable divider of the system clock. Outgoing bits change on the falling serial-clock edge, and incoming bits are captured on the rising edge.

The host offers command words through a valid/ready handshake and selects the reply length and the clock divider. A one-cycle strobe returns each reply right-aligned on a 16-bit output. When the back-to-back option is set and the next command is already offered as a frame ends, the select line stays low and the next frame starts at once. Otherwise the select line goes high for a full serial-clock period before the next frame can start.

Top module: `mw_frame_engine`

## Requirements
- R1: After reset, `mw_cs_n` is 1, `mw_sk` is 0, `mw_so` is 0, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: Each frame sends the 8-bit command on `mw_so`, most significant bit first, and the bit is stable at each of the first eight rising `mw_sk` edges of the frame.
- R3: The ninth serial-clock period of a frame is a turnaround bit with `mw_so` low. The reply bits are then captured from `mw_si` on the following N rising edges, most significant bit first, so a frame has exactly 9+N rising edges.
- R4: The serial-clock period is 2*(D+1) system clocks with a high phase of D+1 clocks, where D is the divider setting. `mw_sk` changes only on a divider tick.
- R5: After `mw_cs_n` falls, at least two full serial-clock periods pass before the first rising `mw_sk` edge of the frame.
- R6: Between frames that are not merged, `mw_cs_n` stays high for at least one serial-clock period. While `mw_cs_n` is high, `mw_sk` and `mw_so` are both low.
- R7: With `cont_mode` set and a command offered when a frame ends, `mw_cs_n` stays low and the next frame's first rising edge comes exactly one serial-clock period after the previous rising edge.
- R8: `rsp_valid` pulses for exactly one system clock with the reply in `rsp_data[N-1:0]`, and all bits above N are zero.
- R9: `size_sel` holds N-1. Values 0, 1 and 2 give a 4-bit reply.
- R10: The divider is taken from `div_sel` only while the block is idle, and the reply size is taken when a command is accepted. Later changes to either input do not affect the frame in progress.
- R11: A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high while idle, and when `cont_mode` is set it is also high in the cycle that ends the last reply bit. It is low at all other times during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_data | input | 8 | Command word to send |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken this cycle |
| cont_mode | input | 1 | Merge frames while commands keep arriving |
| size_sel | input | 4 | Reply length minus one |
| div_sel | input | 8 | Serial-clock divider D |
| mw_sk | output | 1 | Serial clock |
| mw_cs_n | output | 1 | Active-low select |
| mw_so | output | 1 | Serial data out |
| mw_si | input | 1 | Serial data in |
| rsp_data | output | 16 | Right-aligned reply word |
| rsp_valid | output | 1 | One-cycle reply strobe |

## Verification
The assertions assume that `mw_si` changes only while the serial clock is low, so it is settled well before each rising edge. The bench's responder meets this by updating the input just after each falling edge, which leaves at least D+1 clocks before the next capture. The assertions also assume that the host holds `cmd_valid` and `cmd_data` steady until a transfer completes. The bench changes these inputs only on falling system-clock edges. Right after each command is taken, the bench also changes `div_sel` and `size_sel`, to confirm that the frame still uses the values it latched.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_TURN,
    ST_RESP,
    ST_HOLD
  } mw_state_e;
endpackage

// File: rtl/mw_clk_div.sv
module mw_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = !restart && (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && div_q != '0) |=> !tick); // R4
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int RSP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic             si,
  input  logic             done,
  output logic [RSP_W-1:0] rsp_data,
  output logic             rsp_valid
);
  logic [RSP_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q      <= '0;
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (done) rsp_data <= rx_q;
      if (clear)       rx_q <= '0;
      else if (sample) rx_q <= {rx_q[RSP_W-2:0], si};
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
endmodule

// File: rtl/mw_frame_ctrl.sv
module mw_frame_ctrl
  import mw_pkg::*;
#(
  parameter int CMD_W    = 8,
  parameter int RSP_W    = 16,
  parameter int DIV_W    = 8,
  parameter int MIN_BITS = 4,
  localparam int SZ_W    = $clog2(RSP_W),
  localparam int CNT_W   = $clog2(RSP_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             cmd_valid,
  input  logic             cont_mode,
  input  logic [SZ_W-1:0]  size_sel,
  input  logic [DIV_W-1:0] div_sel,
  output logic             cmd_ready,
  output logic             sk,
  output logic             cs_n,
  output logic             so,
  output logic             restart,
  output logic [DIV_W-1:0] div_q,
  output logic             rx_clear,
  output logic             rx_sample,
  output logic             rx_done
);
  localparam logic [SZ_W-1:0]  SZ_MIN   = SZ_W'(MIN_BITS - 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);

  mw_state_e        state_q;
  logic             hi_q;
  logic [CNT_W-1:0] bit_q;
  logic [CMD_W-1:0] shreg_q;
  logic [SZ_W-1:0]  size_q;
  logic [SZ_W-1:0]  size_eff;
  logic             idle, rise, fall, last_rsp, take;

  assign idle      = (state_q == ST_IDLE);
  assign rise      = tick && !hi_q;
  assign fall      = tick && hi_q;
  assign last_rsp  = fall && (state_q == ST_RESP) && (bit_q == {1'b0, size_q});
  assign cmd_ready = idle || (last_rsp && cont_mode);
  assign take      = cmd_valid && cmd_ready;
  assign size_eff  = (size_sel < SZ_MIN) ? SZ_MIN : size_sel;
  assign restart   = idle;
  assign rx_clear  = take;
  assign rx_sample = rise && (state_q == ST_RESP);
  assign rx_done   = last_rsp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hi_q    <= 1'b0;
      bit_q   <= '0;
      shreg_q <= '0;
      size_q  <= '0;
      div_q   <= '0;
      sk      <= 1'b0;
      cs_n    <= 1'b1;
      so      <= 1'b0;
    end else begin
      if (idle) div_q <= div_sel;
      if (tick) hi_q <= !hi_q;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q <= ST_SETUP;
            cs_n    <= 1'b0;
            shreg_q <= cmd_data;
            size_q  <= size_eff;
            bit_q   <= '0;
          end
        end
        ST_SETUP: begin
          if (fall) begin
            if (bit_q == CNT_W'(1)) begin
              state_q <= ST_CMD;
              bit_q   <= '0;
              so      <= shreg_q[CMD_W-1];
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_CMD: begin
          if (rise) sk <= 1'b1;
          if (fall) begin
            sk <= 1'b0;
            if (bit_q == CMD_LAST) begin
              state_q <= ST_TURN;
              so      <= 1'b0;
              bit_q   <= '0;
            end else begin
              so      <= shreg_q[CMD_W-2];
              shreg_q <= {shreg_q[CMD_W-2:0], 1'b0};
              bit_q   <= bit_q + 1'b1;
            end
          end
        end
        ST_TURN: begin
          if (rise) sk <= 1'b1;
          if (fall) begin
            sk      <= 1'b0;
            state_q <= ST_RESP;
            bit_q   <= '0;
          end
        end
        ST_RESP: begin
          if (rise) sk <= 1'b1;
          if (fall) begin
            sk <= 1'b0;
            if (last_rsp) begin
              bit_q <= '0;
              if (take) begin
                state_q <= ST_CMD;
                shreg_q <= cmd_data;
                so      <= cmd_data[CMD_W-1];
                size_q  <= size_eff;
              end else begin
                state_q <= ST_HOLD;
                cs_n    <= 1'b1;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (fall) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    sk |-> !cs_n); // R6
  AST_SO_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !so); // R6
endmodule

// File: rtl/mw_frame_engine.sv
module mw_frame_engine #(
  parameter int CMD_W    = 8,
  parameter int RSP_W    = 16,
  parameter int DIV_W    = 8,
  parameter int MIN_BITS = 4,
  localparam int SZ_W    = $clog2(RSP_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cont_mode,
  input  logic [SZ_W-1:0]  size_sel,
  input  logic [DIV_W-1:0] div_sel,
  output logic             mw_sk,
  output logic             mw_cs_n,
  output logic             mw_so,
  input  logic             mw_si,
  output logic [RSP_W-1:0] rsp_data,
  output logic             rsp_valid
);
  logic             tick, restart, rx_clear, rx_sample, rx_done;
  logic [DIV_W-1:0] div_q;

  mw_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(restart), .div_q(div_q), .tick(tick)
  );

  mw_frame_ctrl #(
    .CMD_W(CMD_W), .RSP_W(RSP_W), .DIV_W(DIV_W), .MIN_BITS(MIN_BITS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cont_mode(cont_mode),
    .size_sel(size_sel), .div_sel(div_sel), .cmd_ready(cmd_ready),
    .sk(mw_sk), .cs_n(mw_cs_n), .so(mw_so),
    .restart(restart), .div_q(div_q),
    .rx_clear(rx_clear), .rx_sample(rx_sample), .rx_done(rx_done)
  );

  mw_rx_shift #(.RSP_W(RSP_W)) u_rx (
    .clk(clk), .rst(rst), .clear(rx_clear), .sample(rx_sample), .si(mw_si),
    .done(rx_done), .rsp_data(rsp_data), .rsp_valid(rsp_valid)
  );

  AST_SK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(mw_sk) |-> $past(tick)); // R4
  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    rx_sample |=> $rose(mw_sk)); // R3
endmodule

// File: tb/mw_frame_engine_test.sv
module mw_frame_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cont_mode = 1'b0;
  logic [3:0]  size_sel = '0;
  logic [7:0]  div_sel = '0;
  logic        mw_sk, mw_cs_n, mw_so;
  logic        mw_si = 1'b0;
  logic [15:0] rsp_data;
  logic        rsp_valid;

  mw_frame_engine uut (
    .clk(clk), .rst(rst), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cont_mode(cont_mode), .size_sel(size_sel),
    .div_sel(div_sel), .mw_sk(mw_sk), .mw_cs_n(mw_cs_n), .mw_so(mw_so),
    .mw_si(mw_si), .rsp_data(rsp_data), .rsp_valid(rsp_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rsp_of(input logic [7:0] c);
    return {c, c ^ 8'h5A};
  endfunction

  function automatic int nbits(input logic [3:0] sz);
    return (sz < 4'd3) ? 4 : int'(sz) + 1;
  endfunction

  function automatic logic [15:0] exp_rsp(input logic [7:0] c, input int n);
    logic [31:0] m;
    m = (32'h1 << n) - 32'h1;
    return rsp_of(c) & m[15:0];
  endfunction

  // per-frame expectations, indexed in order of acceptance
  logic [7:0] sent_cmd [0:127];
  int         sent_nb  [0:127];
  int         sent_dv  [0:127];
  int sent_n = 0;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // serial responder and line monitor, sampled on falling system-clock edges
  int fi = 0, rcnt = 0, fcnt = 0, rsp_count = 0, cs_rises = 0, last_rcnt = 0;
  longint cs_fall_t = 0, last_rise = 0, gap_t = 0;
  int last_dv = 0;
  bit first_rise = 0, have_gap = 0, idle_bad = 0, prev_sk = 0, prev_cs = 1, prev_rv = 0;
  logic [15:0] last_rsp = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_rv && rsp_valid) chk(0, "R8 strobe width", 2, 1);
      if (rsp_valid) begin
        last_rsp = rsp_data;
        chk(rsp_data == exp_rsp(sent_cmd[fi], sent_nb[fi]), "R8 reply word",
            rsp_data, exp_rsp(sent_cmd[fi], sent_nb[fi]));
        rsp_count++;
      end
      if (mw_cs_n && (mw_sk || mw_so)) idle_bad = 1;
      if (prev_cs && !mw_cs_n) begin
        if (have_gap) begin
          chk(cyc - gap_t >= 2*(last_dv+1), "R6 select high gap", cyc - gap_t, 2*(last_dv+1));
          chk(!idle_bad, "R6 lines quiet while deselected", idle_bad, 0);
        end
        cs_fall_t = cyc; first_rise = 1; rcnt = 0; fcnt = 0;
      end
      if (!prev_cs && mw_cs_n) begin
        gap_t = cyc; have_gap = 1; idle_bad = 0; cs_rises++;
      end
      if (!prev_sk && mw_sk) begin
        rcnt++;
        if (first_rise) begin
          chk(cyc - cs_fall_t >= 4*(sent_dv[fi]+1), "R5 select setup",
              cyc - cs_fall_t, 4*(sent_dv[fi]+1));
          first_rise = 0;
        end else begin
          chk(cyc - last_rise == 2*(sent_dv[fi]+1), "R4 R10 clock period",
              cyc - last_rise, 2*(sent_dv[fi]+1));
        end
        last_rise = cyc;
        if (rcnt <= 8) chk(mw_so == sent_cmd[fi][8-rcnt], "R2 command bit", mw_so, sent_cmd[fi][8-rcnt]);
        if (rcnt == 9) chk(mw_so == 1'b0, "R3 turnaround bit low", mw_so, 0);
      end
      if (prev_sk && !mw_sk) begin
        chk(cyc - last_rise == sent_dv[fi]+1, "R4 high phase", cyc - last_rise, sent_dv[fi]+1);
        fcnt++;
        if (fcnt >= 9 && fcnt < 9 + sent_nb[fi])
          mw_si = rsp_of(sent_cmd[fi])[sent_nb[fi]-1-(fcnt-9)];
        else
          mw_si = 1'b0;
        if (fcnt == 9 + sent_nb[fi]) begin
          chk(rcnt == 9 + sent_nb[fi], "R3 edges per frame", rcnt, 9 + sent_nb[fi]);
          last_rcnt = rcnt; last_dv = sent_dv[fi];
          fcnt = 0; rcnt = 0; fi++;
        end
      end
      prev_sk = mw_sk; prev_cs = mw_cs_n; prev_rv = rsp_valid;
    end
  end

  task automatic note(input logic [7:0] c, input logic [3:0] sz, input int dv);
    sent_cmd[sent_n] = c; sent_nb[sent_n] = nbits(sz); sent_dv[sent_n] = dv; sent_n++;
  endtask

  task automatic run_frame(input logic [7:0] c, input logic [3:0] sz, input logic [7:0] dv);
    note(c, sz, int'(dv));
    @(negedge clk);
    cmd_data = c; size_sel = sz; div_sel = dv; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    size_sel = ~sz; div_sel = dv + 8'd3;   // R10: must not disturb this frame
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R11 busy not ready", cmd_ready, 0);
    while (!rsp_valid) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] c, input logic [3:0] sz, input int dv);
    note(c, sz, dv);
    cmd_data = c; size_sel = sz; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mw_cs_n == 1'b1, "R1 select idle", mw_cs_n, 1);
    chk(mw_sk == 1'b0, "R1 clock idle", mw_sk, 0);
    chk(mw_so == 1'b0, "R1 data idle", mw_so, 0);
    chk(rsp_valid == 1'b0, "R1 no strobe", rsp_valid, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);

    // sweep of divider and every legal reply size
    for (int dv = 0; dv < 3; dv++)
      for (int sz = 3; sz < 16; sz++)
        for (int k = 0; k < 2; k++)
          run_frame(8'(37*sz + 91*dv + 113*k + 1), 4'(sz), 8'(dv));

    // R9: small size codes fall back to four reply bits
    for (int sz = 0; sz < 3; sz++) begin
      run_frame(8'hC3 ^ 8'(sz), 4'(sz), 8'd1);
      chk(last_rcnt == 13, "R9 clamp edge count", last_rcnt, 13);
      chk(last_rsp == exp_rsp(8'hC3 ^ 8'(sz), 4), "R9 clamp reply", last_rsp, exp_rsp(8'hC3 ^ 8'(sz), 4));
    end

    // R7: merged frames with select held low
    base = cs_rises;
    @(negedge clk);
    cont_mode = 1'b1; div_sel = 8'd1;
    @(negedge clk);
    push(8'hA6, 4'd7, 1);
    push(8'h19, 4'd15, 1);
    push(8'hF0, 4'd3, 1);
    cmd_valid = 1'b0;
    while (rsp_count < sent_n) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    chk(cs_rises == base + 1, "R7 select held across merged frames", cs_rises, base + 1);
    cont_mode = 1'b0;
    chk(fi == sent_n, "R11 frames accepted", fi, sent_n);

    // one more isolated frame after merged ones
    run_frame(8'h81, 4'd15, 8'd2);
    chk(rsp_count == sent_n, "R8 strobe count", rsp_count, sent_n);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule